// File: doc/BRIEF.md
# Mode-remapped interrupt flag register

This block holds one sticky interrupt flag for each of 32 message mailboxes of a message controller. A one-cycle set pulse from a mailbox raises that mailbox's flag, and the flag stays up until the CPU writes a one to its bit. The CPU reads the flags back on a read bus. A 32-bit mask selects which visible flags drive the single CPU interrupt line.

When the receive FIFO mode is switched on, the low flag byte stops reporting mailbox completion. Bits 5, 6 and 7 then carry FIFO events. Writing a one to bit 0 pops the FIFO. Bits 4 to 1 are reserved. The mailboxes taken over by the FIFO's filter table no longer set their flags, and the size of that region follows a filter-count setting.

With FIFO DMA mode also on, only the frames-available flag remains in use. It drives a DMA request instead of the interrupt, and the CPU cannot clear it. The DMA acknowledge clears it and pops the FIFO.

Top module: `irq_flag_remap`

## Requirements
- R1: Reset clears every flag and holds `cpu_irq`, `dma_req` and `fifo_pop` low.
- R2: In normal mode, a `mb_set[i]` pulse with i at or below `last_mb` makes bit i of `flags` read 1 after the next clock edge.
- R3: A write with `wr_en` high clears every flag whose `wr_data` bit is 1. When a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: `cpu_irq` is high exactly when some visible flag is set and its `mask` bit is 1, not counting flags reserved for DMA.
- R5: With `fifo_en` high, `fifo_evt[0]` sets bit 5 (frames available), `fifo_evt[1]` sets bit 6 (almost full) and `fifo_evt[2]` sets bit 7 (overflow).
- R6: With `fifo_en` high, bits 4 to 0 read zero, and `mb_set` is ignored for mailboxes 0 through 7+2·`filt_cnt`. A `filt_cnt` of 8 covers mailboxes 0 to 23.
- R7: With `fifo_en` high, a CPU write-one to bit 0 raises `fifo_pop` for exactly one cycle, after the next clock edge.
- R8: With both `fifo_en` and `dma_en` high, only bit 5 is visible. `fifo_evt[1]` and `fifo_evt[2]` are ignored. `dma_req` equals bit 5. The low byte never drives `cpu_irq`, whatever the mask.
- R9: With both modes on, a CPU write-one to bit 5 has no effect. `dma_ack` clears bit 5 and raises `fifo_pop` for one cycle after the next edge.
- R10: A set pulse for a mailbox above `last_mb` is ignored. Flags already set above a newly lowered `last_mb` stay set until the CPU clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | Receive FIFO mode |
| dma_en | input | 1 | FIFO DMA mode (acts only with fifo_en) |
| filt_cnt | input | 4 | Filter-count setting that sizes the FIFO-owned region |
| last_mb | input | 5 | Index of the highest active mailbox |
| mb_set | input | 32 | Per-mailbox completion pulses |
| fifo_evt | input | 3 | FIFO events: available, almost full, overflow |
| wr_en | input | 1 | CPU write strobe to the flag register |
| wr_data | input | 32 | Write-one-to-clear data |
| mask | input | 32 | Interrupt enable per flag |
| dma_ack | input | 1 | DMA controller has taken the request |
| flags | output | 32 | Flag read-back as seen in the current mode |
| cpu_irq | output | 1 | Combined CPU interrupt |
| dma_req | output | 1 | FIFO DMA request |
| fifo_pop | output | 1 | One-cycle FIFO pop strobe |

## Verification
A stored flag that is wrong shows on `flags` one edge after the bad update. It also moves `cpu_irq` in the same cycle, as long as the flag is visible and its mask bit is set. Two kinds of fault stay hidden until the mode changes: a wrongly set mailbox bit inside the FIFO region, and a wrongly kept reserved bit. Each becomes visible as soon as FIFO mode is switched off. For that reason the vectors go from normal mode into FIFO mode and back. A pop or DMA fault shows as a missing or extra `fifo_pop` pulse exactly one cycle after the write or acknowledge that should cause it.

// File: rtl/irq_flag_remap.sv
module irq_flag_remap #(
  parameter int NFLAG = 32,
  parameter int FCW   = 4,
  parameter int MBW   = $clog2(NFLAG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             dma_en,
  input  logic [FCW-1:0]   filt_cnt,
  input  logic [MBW-1:0]   last_mb,
  input  logic [NFLAG-1:0] mb_set,
  input  logic [2:0]       fifo_evt,
  input  logic             wr_en,
  input  logic [NFLAG-1:0] wr_data,
  input  logic [NFLAG-1:0] mask,
  input  logic             dma_ack,
  output logic [NFLAG-1:0] flags,
  output logic             cpu_irq,
  output logic             dma_req,
  output logic             fifo_pop
);
  localparam int RW = FCW + 2 > MBW + 1 ? FCW + 2 : MBW + 1;

  logic [NFLAG-1:0] q, vis, set_ok, set_v, clr_v, irq_sel;
  logic [RW-1:0]    rtop;
  logic             dmode;
  logic             pop_q;

  assign dmode = fifo_en & dma_en;
  assign rtop  = RW'(7) + RW'({filt_cnt, 1'b0});

  always_comb begin
    for (int i = 0; i < NFLAG; i++)
      set_ok[i] = (MBW'(i) <= last_mb) && !(fifo_en && (RW'(i) <= rtop));
    set_v = mb_set & set_ok;
    if (fifo_en) begin
      set_v[5] = set_v[5] | fifo_evt[0];
      if (!dma_en) begin
        set_v[6] = set_v[6] | fifo_evt[1];
        set_v[7] = set_v[7] | fifo_evt[2];
      end
    end
    clr_v = wr_en ? wr_data : '0;
    if (dmode) clr_v[5] = dma_ack;
    vis = '1;
    if (fifo_en) vis[4:0] = '0;
    if (dmode) vis[7:6] = '0;
    irq_sel = vis;
    if (dmode) irq_sel[7:0] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q     <= '0;
      pop_q <= 1'b0;
    end else begin
      q     <= (q & ~clr_v) | set_v;
      pop_q <= fifo_en & ((wr_en & wr_data[0]) | (dma_en & dma_ack));
    end
  end

  assign flags    = q & vis;
  assign cpu_irq  = |(flags & mask & irq_sel);
  assign dma_req  = dmode & q[5];
  assign fifo_pop = pop_q;

  assert_pop_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> $past(fifo_en && ((wr_en && wr_data[0]) || (dma_en && dma_ack))))
    else $error("pop strobe without cause");

  assert_dma_cpu_noclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dmode && q[5] && !dma_ack) |=> q[5])
    else $error("flag 5 lost in DMA mode without acknowledge");

  assert_persist_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & $past(q & ~clr_v)) == $past(q & ~clr_v)))
    else $error("flag dropped without a clear");

  assert_dmareq_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (fifo_en && dma_en && !(flags[7] || flags[6])))
    else $error("DMA request outside DMA mode");

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (q == '0 && !fifo_pop))
    else $error("reset left state");
endmodule

// File: tb/sim_irq_flag_remap.sv
`timescale 1ns/1ps
module sim_irq_flag_remap;
  logic clk = 0, rst_n = 0;
  logic fifo_en = 0, dma_en = 0, wr_en = 0, dma_ack = 0;
  logic [3:0] filt_cnt = 0;
  logic [4:0] last_mb = 5'd31;
  logic [31:0] mb_set = 0, wr_data = 0, mask = 0;
  logic [2:0] fifo_evt = 0;
  logic [31:0] flags;
  logic cpu_irq, dma_req, fifo_pop;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  irq_flag_remap u0 (.clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_en(dma_en),
    .filt_cnt(filt_cnt), .last_mb(last_mb), .mb_set(mb_set), .fifo_evt(fifo_evt),
    .wr_en(wr_en), .wr_data(wr_data), .mask(mask), .dma_ack(dma_ack),
    .flags(flags), .cpu_irq(cpu_irq), .dma_req(dma_req), .fifo_pop(fifo_pop));

  typedef struct packed {
    logic fe, de; logic [3:0] fc; logic [4:0] lm; logic [31:0] ms; logic [2:0] ev;
    logic we; logic [31:0] wd; logic [31:0] mk; logic ack;
    logic [31:0] xf; logic xi, xd, xp;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,4'd0,5'd31,32'h00000013,3'd0,1'b0,32'h0,32'hFFFFFFFF,1'b0, 32'h00000013,1'b1,1'b0,1'b0}, // R2
    '{1'b0,1'b0,4'd0,5'd31,32'h0,3'd0,1'b1,32'h00000002,32'hFFFFFFFF,1'b0, 32'h00000011,1'b1,1'b0,1'b0}, // R3
    '{1'b0,1'b0,4'd0,5'd31,32'h00000100,3'd0,1'b1,32'h00000100,32'hFFFFFFFF,1'b0, 32'h00000111,1'b1,1'b0,1'b0}, // R3 set wins
    '{1'b0,1'b0,4'd0,5'd31,32'h0,3'd0,1'b1,32'h00000111,32'hFFFFFFFF,1'b0, 32'h0,1'b0,1'b0,1'b0}, // R3
    '{1'b0,1'b0,4'd0,5'd31,32'h80000000,3'd0,1'b0,32'h0,32'h0,1'b0, 32'h80000000,1'b0,1'b0,1'b0}, // R4 masked
    '{1'b0,1'b0,4'd0,5'd31,32'h0,3'd0,1'b1,32'h80000000,32'hFFFFFFFF,1'b0, 32'h0,1'b0,1'b0,1'b0}, // R4
    '{1'b1,1'b0,4'd0,5'd31,32'h000001FF,3'd3,1'b0,32'h0,32'hFFFFFFFF,1'b0, 32'h00000160,1'b1,1'b0,1'b0}, // R5
    '{1'b1,1'b0,4'd8,5'd31,32'h01FFFF00,3'd0,1'b1,32'h00000001,32'hFFFFFFFF,1'b0, 32'h01000160,1'b1,1'b0,1'b1}, // R6 R7
    '{1'b1,1'b0,4'd0,5'd31,32'h0,3'd0,1'b1,32'h01000140,32'h00000020,1'b0, 32'h00000020,1'b1,1'b0,1'b0}, // R4 fifo
    '{1'b1,1'b1,4'd0,5'd31,32'h0,3'd4,1'b1,32'h00000020,32'hFFFFFFFF,1'b0, 32'h00000020,1'b0,1'b1,1'b0}, // R8 R9
    '{1'b1,1'b1,4'd0,5'd31,32'h0,3'd0,1'b0,32'h0,32'hFFFFFFFF,1'b1, 32'h0,1'b0,1'b0,1'b1}, // R9 ack
    '{1'b1,1'b1,4'd0,5'd31,32'h0,3'd1,1'b0,32'h0,32'hFFFFFFFF,1'b1, 32'h00000020,1'b0,1'b1,1'b1}, // R9 set wins
    '{1'b0,1'b0,4'd0,5'd31,32'h0,3'd0,1'b1,32'h00000020,32'hFFFFFFFF,1'b0, 32'h0,1'b0,1'b0,1'b0}, // R3
    '{1'b0,1'b0,4'd0,5'd3,32'h00000018,3'd0,1'b0,32'h0,32'hFFFFFFFF,1'b0, 32'h00000008,1'b1,1'b0,1'b0}, // R10
    '{1'b0,1'b0,4'd0,5'd31,32'h00010000,3'd0,1'b0,32'h0,32'hFFFFFFFF,1'b0, 32'h00010008,1'b1,1'b0,1'b0}, // R2
    '{1'b0,1'b0,4'd0,5'd3,32'h00020000,3'd0,1'b0,32'h0,32'hFFFFFFFF,1'b0, 32'h00010008,1'b1,1'b0,1'b0}, // R10 persist
    '{1'b0,1'b0,4'd0,5'd31,32'h0,3'd0,1'b1,32'hFFFFFFFF,32'hFFFFFFFF,1'b0, 32'h0,1'b0,1'b0,1'b0}, // R3
    '{1'b0,1'b0,4'd0,5'd31,32'h0000001E,3'd0,1'b0,32'h0,32'hFFFFFFFF,1'b0, 32'h0000001E,1'b1,1'b0,1'b0}, // R2
    '{1'b1,1'b0,4'd0,5'd31,32'h0,3'd0,1'b0,32'h0,32'hFFFFFFFF,1'b0, 32'h0,1'b0,1'b0,1'b0}, // R6 reserved
    '{1'b0,1'b0,4'd0,5'd31,32'h0,3'd0,1'b1,32'h0000001E,32'hFFFFFFFF,1'b0, 32'h0,1'b0,1'b0,1'b0}  // R3
  };

  function automatic string tag(int k);
    case (k)
      0, 14, 17: return "R2";
      1, 2, 3, 12, 16, 19: return "R3";
      4, 5, 8: return "R4";
      6: return "R5";
      7, 18: return "R6";
      9: return "R8";
      10, 11: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic idle();
    mb_set = 0; fifo_evt = 0; wr_en = 0; wr_data = 0; dma_ack = 0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "flags", flags, 0);
    chk("R1", "irq/dreq/pop", {29'b0, cpu_irq, dma_req, fifo_pop}, 0);
    rst_n = 1;
    for (int k = 0; k < NV; k++) begin
      fifo_en = TBL[k].fe; dma_en = TBL[k].de; filt_cnt = TBL[k].fc; last_mb = TBL[k].lm;
      mb_set = TBL[k].ms; fifo_evt = TBL[k].ev; wr_en = TBL[k].we; wr_data = TBL[k].wd;
      mask = TBL[k].mk; dma_ack = TBL[k].ack;
      @(posedge clk); #1;
      chk(tag(k), "flags", flags, TBL[k].xf);
      chk(tag(k), "cpu_irq", {31'b0, cpu_irq}, {31'b0, TBL[k].xi});
      chk(tag(k), "dma_req", {31'b0, dma_req}, {31'b0, TBL[k].xd});
      chk(tag(k), "fifo_pop", {31'b0, fifo_pop}, {31'b0, TBL[k].xp});
    end
    idle();
    // R7: pop lasts exactly one cycle
    fifo_en = 1; dma_en = 0; wr_en = 1; wr_data = 32'h1;
    @(posedge clk); #1;
    chk("R7", "pop first cycle", {31'b0, fifo_pop}, 1);
    idle();
    @(posedge clk); #1;
    chk("R7", "pop second cycle", {31'b0, fifo_pop}, 0);
    // R7: no pop in normal mode
    fifo_en = 0; wr_en = 1; wr_data = 32'h1;
    @(posedge clk); #1;
    chk("R7", "pop normal mode", {31'b0, fifo_pop}, 0);
    idle();
    // R8: low byte never interrupts in DMA mode even with mask set
    fifo_en = 1; dma_en = 1; mask = 32'hFFFFFFFF; fifo_evt = 3'b001;
    @(posedge clk); #1;
    idle();
    chk("R8", "cpu_irq dma", {31'b0, cpu_irq}, 0);
    chk("R8", "dma_req", {31'b0, dma_req}, 1);
    // R1: reset mid-run
    mb_set = 32'h40000000;
    @(posedge clk); #1;
    idle();
    rst_n = 0;
    @(posedge clk); #1;
    chk("R1", "flags after reset", flags, 0);
    chk("R1", "dma_req after reset", {31'b0, dma_req}, 0);
    chk("R1", "cpu_irq after reset", {31'b0, cpu_irq}, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule